// File: doc/BRIEF.md
# Bus-Restarted Watchdog Timer

This block is the watchdog part of a CPU supervisor. Software proves it is alive by starting a transaction on a two-wire serial bus. The block watches the clock and data lines. A START condition is the data line falling while the clock line is high. Each valid START clears the watchdog count. If no START arrives within the selected period, the block raises a sticky expiry flag and drives a reset pulse. It then counts a fresh period from zero. The cycle of period, pulse and period again repeats for as long as the bus stays quiet.

A two-bit code selects the period: long, medium or short. A fourth code switches the watchdog off, and that code is the value after reset. The reset pulse is long after a long or medium period and short after a short period. All durations are counted in ticks from an internal prescaler. Every duration is a parameter, so a bench can shrink them. The defaults give a 1 µs tick from a 50 MHz clock: 1.4 s, 200 ms and 25 ms periods, a 200 ms or 25 ms pulse, and a 1 µs minimum data-high time before a START.

Top module: `bus_watchdog`

## Requirements
- R1: After reset the period code is 2'b11 (off). With code 2'b11, `reset_out` and `expired` stay low however long the bus is idle.
- R2: With code 2'b00, 2'b01 or 2'b10, a count of `PERIOD_LONG`, `PERIOD_MID` or `PERIOD_SHORT` ticks with no valid START makes `reset_out` rise and sets `expired`.
- R3: The reset pulse lasts `PULSE_LONG` ticks after a timeout under code 2'b00 or 2'b01, and `PULSE_SHORT` ticks under code 2'b10.
- R4: When a pulse ends, counting restarts from zero. With no START, the next pulse rises exactly one full period after the previous pulse fell.
- R5: A valid START restarts the count from zero and clears `expired`. A valid START is `sda_in` falling while `scl_in` is high, after `sda_in` has been high for at least `MIN_HIGH` ticks.
- R6: The count is not restarted by an `sda_in` fall that follows a high time shorter than `MIN_HIGH` ticks. It is also not restarted by an `sda_in` fall while `scl_in` is low.
- R7: A START during a reset pulse is ignored. The pulse keeps its full length, `expired` stays set, and counting resumes from zero when the pulse ends.
- R8: A `cfg_load` cycle takes in `cfg_code`, ends any pulse, clears `expired` and restarts the count from zero. Loading 2'b11 leaves both outputs low from the next cycle on.
- R9: `expired` stays set from a timeout until the next valid START or `cfg_load`, including after the pulse ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Serial bus clock line, asynchronous |
| sda_in | input | 1 | Serial bus data line, asynchronous |
| cfg_load | input | 1 | One-cycle strobe that loads `cfg_code` |
| cfg_code | input | 2 | Period code: 00 long, 01 medium, 10 short, 11 off |
| expired | output | 1 | Sticky flag: a timeout happened and has not been serviced |
| reset_out | output | 1 | Active-high supervisor reset pulse |

## Verification
The hardest case to reach is a START that lands inside a reset pulse. The bench keeps the data line high through the whole timeout, so no START can occur early. It waits for the pulse to rise, then drops the data line at once. The synchroniser and detection delay still leave several cycles of pulse after the START is seen. The bench then checks that the pulse width is exact and that the next rise comes exactly one period after the fall. A second hard case is a data-line fall that is not a valid START, either because the high time was too short or because the clock line was low. The bench checks these by showing that the timeout still arrives in the window counted from the configuration load.

// File: rtl/wd_pkg.sv
// Package: shared state type, period codes and a sizing helper for the
// bus-restarted watchdog. Assumes nothing beyond IEEE 1800-2017.
package wd_pkg;

    typedef enum logic [1:0] {
        WD_OFF   = 2'd0,
        WD_COUNT = 2'd1,
        WD_PULSE = 2'd2
    } wd_state_e;

    localparam logic [1:0] CODE_LONG  = 2'b00;
    localparam logic [1:0] CODE_MID   = 2'b01;
    localparam logic [1:0] CODE_SHORT = 2'b10;
    localparam logic [1:0] CODE_OFF   = 2'b11;

    // Largest of five tick counts, used to size the shared counter.
    function automatic int wd_max5(input int a, input int b, input int c,
                                   input int d, input int e);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        if (e > m) m = e;
        return m;
    endfunction

endpackage

// File: rtl/wd_prescaler.sv
// Module: wd_prescaler
// Divides the clock into a one-cycle tick every DIV clocks.
// Assumes DIV >= 1; with DIV == 1 the tick is high on every cycle.
module wd_prescaler #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] div_cnt;

    // Wrap the divider and emit one tick per wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
            tick    <= 1'b1;
        end else begin
            div_cnt <= div_cnt + 1'b1;
            tick    <= 1'b0;
        end
    end
endmodule

// File: rtl/wd_sync2.sv
// Module: wd_sync2
// Two-flop synchroniser for W asynchronous inputs, reset to RST_VAL.
// Assumes each input is a level that is stable for several clocks.
module wd_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] meta;

    // Two register stages into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta     <= RST_VAL;
            sync_out <= RST_VAL;
        end else begin
            meta     <= async_in;
            sync_out <= meta;
        end
    end
endmodule

// File: rtl/wd_start_detect.sv
// Module: wd_start_detect
// Finds bus START conditions: data falling while the clock line is high,
// after the data line has been high for at least MIN_HIGH ticks.
// Assumes an idle bus with both lines high; the output is a one-cycle pulse.
module wd_start_detect #(
    parameter int MIN_HIGH = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic scl_in,
    input  logic sda_in,
    output logic start_evt
);
    localparam int HW = $clog2(MIN_HIGH + 1);
    localparam logic [HW-1:0] HMAX = HW'(MIN_HIGH);

    logic [1:0]    bus_s;
    logic          scl_s;
    logic          sda_s;
    logic          sda_prev;
    logic [HW-1:0] high_ticks;
    logic          qualified;

    wd_sync2 #(.W(2), .RST_VAL(2'b11)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (bus_s)
    );

    assign scl_s = bus_s[1];
    assign sda_s = bus_s[0];

    // Track the data level of the previous cycle for edge finding.
    always_ff @(posedge clk) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_s;
    end

    // Count ticks of data-high time, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)                          high_ticks <= '0;
        else if (!sda_s)                     high_ticks <= '0;
        else if (tick && high_ticks != HMAX) high_ticks <= high_ticks + 1'b1;
    end

    assign qualified = sda_prev && !sda_s && scl_s && (high_ticks >= HMAX);

    // Register the qualified START as a clean one-cycle event.
    always_ff @(posedge clk) begin
        if (!rst_n) start_evt <= 1'b0;
        else        start_evt <= qualified;
    end
endmodule

// File: rtl/wd_timer.sv
// Module: wd_timer
// Holds the period code and runs the count/pulse sequence on one shared
// tick counter. Assumes all tick counts are >= 1 and start_evt is a pulse.
module wd_timer
    import wd_pkg::*;
#(
    parameter int PERIOD_LONG  = 1400000,
    parameter int PERIOD_MID   = 200000,
    parameter int PERIOD_SHORT = 25000,
    parameter int PULSE_LONG   = 200000,
    parameter int PULSE_SHORT  = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       start_evt,
    input  logic       cfg_load,
    input  logic [1:0] cfg_code,
    output logic [1:0] code_q,
    output logic       expired,
    output logic       reset_out
);
    localparam int MAXV = wd_max5(PERIOD_LONG, PERIOD_MID, PERIOD_SHORT,
                                  PULSE_LONG, PULSE_SHORT);
    localparam int CW   = $clog2(MAXV + 1);

    wd_state_e      state;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  period_last;
    logic [CW-1:0]  pulse_last;

    // Pick the final count of the period and of the pulse from the code.
    always_comb begin
        case (code_q)
            CODE_LONG: period_last = CW'(PERIOD_LONG - 1);
            CODE_MID:  period_last = CW'(PERIOD_MID - 1);
            default:   period_last = CW'(PERIOD_SHORT - 1);
        endcase
        pulse_last = (code_q == CODE_SHORT) ? CW'(PULSE_SHORT - 1)
                                            : CW'(PULSE_LONG - 1);
    end

    // Sequence: off, counting a period, or driving the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= CODE_OFF;
            state   <= WD_OFF;
            cnt     <= '0;
            expired <= 1'b0;
        end else if (cfg_load) begin
            code_q  <= cfg_code;
            cnt     <= '0;
            expired <= 1'b0;
            state   <= (cfg_code == CODE_OFF) ? WD_OFF : WD_COUNT;
        end else begin
            case (state)
                WD_COUNT: begin
                    if (start_evt) begin
                        cnt     <= '0;
                        expired <= 1'b0;
                    end else if (tick) begin
                        if (cnt == period_last) begin
                            state   <= WD_PULSE;
                            cnt     <= '0;
                            expired <= 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                WD_PULSE: begin
                    if (tick) begin
                        if (cnt == pulse_last) begin
                            state <= WD_COUNT;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    assign reset_out = (state == WD_PULSE);
endmodule

// File: rtl/bus_watchdog.sv
// Module: bus_watchdog (top)
// Watchdog serviced by START conditions on a two-wire bus. A timeout sets a
// sticky flag and drives a reset pulse, after which counting starts again.
// Assumes scl_in/sda_in are asynchronous; durations are in prescaler ticks.
module bus_watchdog #(
    parameter int TICK_DIV     = 50,
    parameter int MIN_HIGH     = 1,
    parameter int PERIOD_LONG  = 1400000,
    parameter int PERIOD_MID   = 200000,
    parameter int PERIOD_SHORT = 25000,
    parameter int PULSE_LONG   = 200000,
    parameter int PULSE_SHORT  = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       cfg_load,
    input  logic [1:0] cfg_code,
    output logic       expired,
    output logic       reset_out
);
    logic       tick;
    logic       start_evt;
    logic [1:0] code_q;

    wd_prescaler #(.DIV(TICK_DIV)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    wd_start_detect #(.MIN_HIGH(MIN_HIGH)) u_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .start_evt (start_evt)
    );

    wd_timer #(
        .PERIOD_LONG  (PERIOD_LONG),
        .PERIOD_MID   (PERIOD_MID),
        .PERIOD_SHORT (PERIOD_SHORT),
        .PULSE_LONG   (PULSE_LONG),
        .PULSE_SHORT  (PULSE_SHORT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .start_evt (start_evt),
        .cfg_load  (cfg_load),
        .cfg_code  (cfg_code),
        .code_q    (code_q),
        .expired   (expired),
        .reset_out (reset_out)
    );
endmodule

// File: rtl/wd_checker.sv
// Module: wd_checker
// Properties of the watchdog's outputs against its code, START events and
// configuration strobe. Bound to bus_watchdog below.
module wd_checker #(
    parameter int TICK_DIV    = 50,
    parameter int PULSE_LONG  = 200000,
    parameter int PULSE_SHORT = 25000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_load,
    input logic [1:0] cfg_code,
    input logic [1:0] code_q,
    input logic       start_evt,
    input logic       expired,
    input logic       reset_out
);
    localparam int PMAX = (PULSE_LONG > PULSE_SHORT) ? PULSE_LONG : PULSE_SHORT;
    localparam int MAXW = PMAX * TICK_DIV;
    localparam int WW   = $clog2(MAXW + 1);

    logic [WW-1:0] run_len;

    // Count consecutive cycles with the pulse high.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_len <= '0;
        else if (reset_out) run_len <= run_len + 1'b1;
        else                run_len <= '0;
    end

    a_r1_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q == 2'b11) |-> !reset_out);

    a_r3_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        reset_out |-> (run_len < WW'(MAXW)));

    a_r9_flag_during_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        reset_out |-> expired);

    a_r8_off_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load && cfg_code == 2'b11) |=> (!reset_out && !expired));

    a_r7_start_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (reset_out && start_evt && !cfg_load) |=> expired);

    a_r5_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !reset_out && !cfg_load) |=> !expired);
endmodule

bind bus_watchdog wd_checker #(
    .TICK_DIV    (TICK_DIV),
    .PULSE_LONG  (PULSE_LONG),
    .PULSE_SHORT (PULSE_SHORT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_load  (cfg_load),
    .cfg_code  (cfg_code),
    .code_q    (code_q),
    .start_evt (start_evt),
    .expired   (expired),
    .reset_out (reset_out)
);

// File: tb/sim_bus_watchdog.sv
// Bench: scoreboard of expected pulses. Driver pushes expected rise windows
// and widths; a monitor pops and compares them as pulses appear.
module sim_bus_watchdog;
    localparam int D  = 2;
    localparam int PL = 40, PM = 20, PS = 10;
    localparam int RL = 8,  RS = 4;
    localparam int MH = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl_in = 1'b1, sda_in = 1'b1;
    logic cfg_load = 1'b0;
    logic [1:0] cfg_code = 2'b11;
    logic expired, reset_out;

    always #10 clk = ~clk;

    bus_watchdog #(
        .TICK_DIV(D), .MIN_HIGH(MH), .PERIOD_LONG(PL), .PERIOD_MID(PM),
        .PERIOD_SHORT(PS), .PULSE_LONG(RL), .PULSE_SHORT(RS)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .cfg_load(cfg_load), .cfg_code(cfg_code),
        .expired(expired), .reset_out(reset_out)
    );

    typedef struct {
        string tag;
        int    lo;
        int    hi;
        int    width;
        bit    from_fall;
    } exp_t;

    exp_t q[$];
    int   cyc = 0, t_ref = 0, t_fall = 0, t_rise = 0;
    int   checks = 0, errors = 0;
    bit   done = 1'b0;
    int   cur_width = 0;
    string cur_tag = "";
    logic prev_ro = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic expect_pulse(input string tag, input int lo, input int hi,
                                input int width, input bit from_fall);
        exp_t e;
        e.tag = tag; e.lo = lo; e.hi = hi; e.width = width; e.from_fall = from_fall;
        q.push_back(e);
    endtask

    // Monitor: compare each pulse edge against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !prev_ro && reset_out) begin
            t_rise = cyc;
            if (q.size() == 0) begin
                chk(1'b0, "R1/R5/R6 unexpected pulse", 1, 0);
                cur_width = 0;
            end else begin
                exp_t e;
                int el;
                e = q.pop_front();
                el = cyc - (e.from_fall ? t_fall : t_ref);
                chk(el >= e.lo && el <= e.hi, e.tag, el, e.lo);
                cur_width = e.width;
                cur_tag = e.tag;
            end
        end
        if (rst_n && prev_ro && !reset_out) begin
            t_fall = cyc;
            if (cur_width > 0) chk(cyc - t_rise == cur_width, {cur_tag, " R3 width"},
                                   cyc - t_rise, cur_width);
        end
        prev_ro = reset_out;
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [1:0] c);
        @(negedge clk);
        cfg_load = 1'b1; cfg_code = c; t_ref = cyc;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    task automatic wait_ro(input logic lvl, input string req);
        int n;
        n = 0;
        while (reset_out !== lvl && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (reset_out !== lvl) chk(1'b0, {req, " pulse edge missing"}, reset_out, lvl);
    endtask

    task automatic bus_start();
        @(negedge clk); sda_in = 1'b1;
        wait_cyc(8);
        sda_in = 1'b0; t_ref = cyc;
        wait_cyc(4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and code 11 quiet
        chk(reset_out == 1'b0, "R1 reset_out after reset", reset_out, 0);
        chk(expired == 1'b0, "R1 expired after reset", expired, 0);
        wait_cyc(100);
        chk(expired == 1'b0, "R1 expired stays low while off", expired, 0);

        // R2/R3/R4 short code, then automatic rearm
        load(2'b10);
        expect_pulse("R2 short timeout", (PS-1)*D, PS*D+2, RS*D, 1'b0);
        expect_pulse("R4 rearm short", PS*D, PS*D, RS*D, 1'b1);
        wait_ro(1, "R2"); wait_ro(0, "R2"); wait_ro(1, "R4"); wait_ro(0, "R4");
        chk(expired == 1'b1, "R9 expired held after pulse", expired, 1);
        load(2'b11);
        chk(reset_out == 1'b0 && expired == 1'b0, "R8 off clears", expired, 0);

        // R2/R3 medium code
        load(2'b01);
        expect_pulse("R2 mid timeout", (PM-1)*D, PM*D+2, RL*D, 1'b0);
        wait_ro(1, "R2");
        @(negedge clk);
        chk(expired == 1'b1, "R2 expired on timeout", expired, 1);
        wait_ro(0, "R2");
        load(2'b11);

        // R2/R3 long code
        load(2'b00);
        expect_pulse("R2 long timeout", (PL-1)*D, PL*D+2, RL*D, 1'b0);
        wait_ro(1, "R2"); wait_ro(0, "R2");
        load(2'b11);

        // R5: regular STARTs keep the pulse away, then it times out
        load(2'b10);
        for (int i = 0; i < 10; i++) bus_start();
        expect_pulse("R5 timeout after last START", (PS-1)*D, PS*D+6, RS*D, 1'b0);
        wait_ro(1, "R5"); wait_ro(0, "R5");
        chk(expired == 1'b1, "R9 expired before service", expired, 1);
        bus_start();
        chk(expired == 1'b0, "R5 START clears expired", expired, 0);
        load(2'b11);

        // R6: short data-high pulses are not STARTs
        sda_in = 1'b0;
        wait_cyc(6);
        load(2'b10);
        expect_pulse("R6 short-high ignored", (PS-1)*D, PS*D+2, RS*D, 1'b0);
        for (int i = 0; i < 5; i++) begin
            sda_in = 1'b1; wait_cyc(2);
            sda_in = 1'b0; wait_cyc(2);
        end
        wait_ro(1, "R6"); wait_ro(0, "R6");
        load(2'b11);

        // R6: data falling with the clock line low is not a START
        wait_cyc(6);
        load(2'b10);
        expect_pulse("R6 fall with clock low ignored", (PS-1)*D, PS*D+2, RS*D, 1'b0);
        scl_in = 1'b0; wait_cyc(1);
        sda_in = 1'b1; wait_cyc(8);
        sda_in = 1'b0; wait_cyc(3);
        scl_in = 1'b1;
        wait_ro(1, "R6"); wait_ro(0, "R6");
        load(2'b11);
        sda_in = 1'b1;
        wait_cyc(10);

        // R7: START inside the pulse is ignored
        load(2'b10);
        expect_pulse("R7 timeout", (PS-1)*D, PS*D+2, RS*D, 1'b0);
        expect_pulse("R7 rearm after START in pulse", PS*D, PS*D, RS*D, 1'b1);
        wait_ro(1, "R7");
        sda_in = 1'b0;
        wait_cyc(6);
        chk(expired == 1'b1, "R7 expired kept during pulse", expired, 1);
        sda_in = 1'b1;
        wait_ro(0, "R7"); wait_ro(1, "R7"); wait_ro(0, "R7");
        load(2'b11);

        // R8: code change restarts the count
        load(2'b01);
        wait_cyc(30);
        load(2'b10);
        expect_pulse("R8 count restarted by load", (PS-1)*D, PS*D+2, RS*D, 1'b0);
        wait_ro(1, "R8"); wait_ro(0, "R8");
        load(2'b11);

        // R8: loading off ends a pulse at once
        load(2'b10);
        expect_pulse("R8 pulse before off", (PS-1)*D, PS*D+2, 0, 1'b0);
        wait_ro(1, "R8");
        wait_cyc(2);
        load(2'b11);
        chk(reset_out == 1'b0, "R8 off ends pulse", reset_out, 0);
        chk(expired == 1'b0, "R8 off clears expired", expired, 0);
        wait_cyc(100);
        chk(q.size() == 0, "R1 scoreboard drained", q.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule